// File: doc/BRIEF.md
# DDR ADC Sample Capture to Stream

This block receives 12-bit samples from an analog-to-digital converter that drives six double-data-rate lanes alongside its own output clock. Each lane moves a pair of neighbouring sample bits in every clock period: one bit on the rising half and one on the falling half. The block holds the two halves in separate modelled input registers. On the next rising edge it joins them into a complete 12-bit word, so it produces one sample per clock period.

If the clock reaches the capture logic inverted, the halves of each pair arrive in the wrong order. A configuration input swaps them back. A second configuration input picks the number format. The converter's native offset-binary code can pass through zero-extended to 16 bits. It can also be turned into two's complement by flipping the top bit, and is then sign-extended. Finished words leave on a valid/ready stream. The output register has one spare slot behind it. When both are full, further samples are thrown away and a sticky flag records the loss.

Top module: `ddr_sample_stream`

## Requirements
- R1: With `swapPair` low, lane k gives sample bit 2k from the value captured on the rising edge and bit 2k+1 from the value captured on the following falling edge, for k = 0 to 5.
- R2: With `swapPair` high, lane k gives sample bit 2k+1 from the rising-edge value and bit 2k from the falling-edge value.
- R3: A sample marks its rising half with `laneValid` high at rising edge P. When the output is empty, `tvalid` rises after rising edge P+2 and not before.
- R4: With `twosComp` low, `tdata` equals the 12-bit code in bits 11:0, with bits 15:12 zero.
- R5: With `twosComp` high, `tdata` bits 10:0 equal the code, bit 11 is the inverse of the code's bit 11, and bits 15:12 copy bit 11 of `tdata`.
- R6: A sample whose rising half is captured with `laneValid` low produces no stream beat.
- R7: While `tvalid` is high and `tready` is low, `tvalid` stays high and `tdata` keeps its value.
- R8: While the stream is stalled, the block keeps the sample on the output and one more pending sample. These two are delivered in arrival order once `tready` is high.
- R9: A sample that arrives while both the output and the pending slot are full is discarded. `overflow` then rises and stays high until reset.
- R10: Synchronous active-high `rst` clears `tvalid`, the pending slot and `overflow`. No sample captured before reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter output clock; both edges capture lane data |
| rst | input | 1 | Synchronous active-high reset |
| laneData | input | 6 | DDR data lanes; lane k carries sample bits 2k and 2k+1 |
| laneValid | input | 1 | Marks the rising half of a sample as one to keep |
| swapPair | input | 1 | 1 = rising edge holds the odd bit of each pair |
| twosComp | input | 1 | 1 = convert offset binary to sign-extended two's complement |
| tvalid | output | 1 | Stream data valid |
| tready | input | 1 | Stream sink ready |
| tdata | output | 16 | Stream sample, extended to 16 bits |
| overflow | output | 1 | Sticky flag: a sample was dropped |

## Verification
The assertions assume that `swapPair` and `twosComp` stay constant while any sample is in flight. The sign-extension check on `tdata` relies on this. The bench therefore changes either setting only after the stream has drained and several idle cycles have passed. The assertions also assume that lane values are settled around both clock edges. The bench changes lanes only a quarter period away from each edge, putting the rising half in place before the rising edge and the falling half in place before the falling edge. The sweep covers every 12-bit code under all four combinations of pair order and format, with `tready` held high. Stalls and drops are tested separately with known sequences.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

  // Control-to-datapath strobes for the output register and the spare slot.
  typedef struct packed {
    logic loadOutWord;  // output register takes the freshly assembled word
    logic loadOutPend;  // output register takes the spare slot's word
    logic loadPend;     // spare slot takes the freshly assembled word
  } strobe_t;

endpackage

// File: rtl/ddr_cap_datapath.sv
module ddr_cap_datapath
  import ddr_cap_pkg::*;
#(
  parameter int LANES = 6,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] laneData,
  input  logic             laneValid,
  input  logic             swapPair,
  input  logic             twosComp,
  input  strobe_t          strobes,
  output logic             wordValid,
  output logic [OUT_W-1:0] outData
);

  localparam int SAMPLE_W = 2 * LANES;
  localparam int EXT_W    = OUT_W - SAMPLE_W;

  logic [LANES-1:0]    riseQ;
  logic                riseValidQ;
  logic [LANES-1:0]    fallQ;
  logic [SAMPLE_W-1:0] code;
  logic                topBit;
  logic [OUT_W-1:0]    fmtWord;
  logic [OUT_W-1:0]    wordData;
  logic [OUT_W-1:0]    pendData;

  // Modelled DDR input register, rising half
  always_ff @(posedge clk) begin
    if (rst) begin
      riseQ      <= '0;
      riseValidQ <= 1'b0;
    end else begin
      riseQ      <= laneData;
      riseValidQ <= laneValid;
    end
  end

  // Modelled DDR input register, falling half
  always_ff @(negedge clk) begin
    fallQ <= laneData;
  end

  // Pair ordering per lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign code[2*k]   = swapPair ? fallQ[k] : riseQ[k];
    assign code[2*k+1] = swapPair ? riseQ[k] : fallQ[k];
  end

  // Number format and extension
  always_comb begin
    topBit  = code[SAMPLE_W-1] ^ twosComp;
    fmtWord = {(twosComp ? {EXT_W{topBit}} : {EXT_W{1'b0}}), topBit, code[SAMPLE_W-2:0]};
  end

  // Word assembly on the rising edge after both halves are held
  always_ff @(posedge clk) begin
    if (rst) begin
      wordValid <= 1'b0;
      wordData  <= '0;
    end else begin
      wordValid <= riseValidQ;
      wordData  <= fmtWord;
    end
  end

  // Output register and single spare slot
  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      pendData <= '0;
    end else begin
      if (strobes.loadOutWord)      outData <= wordData;
      else if (strobes.loadOutPend) outData <= pendData;
      if (strobes.loadPend)         pendData <= wordData;
    end
  end

  // R3
  lane_to_word_chk: assert property (@(posedge clk) disable iff (rst)
    laneValid |=> ##1 wordValid);

  // R6
  idle_lane_chk: assert property (@(posedge clk) disable iff (rst)
    !laneValid |=> ##1 !wordValid);

endmodule

// File: rtl/ddr_cap_ctrl.sv
module ddr_cap_ctrl
  import ddr_cap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wordValid,
  input  logic    tready,
  output strobe_t strobes,
  output logic    outValid,
  output logic    overflow
);

  logic pendValid;
  logic accept;
  logic drop;

  always_comb begin
    strobes = '0;
    drop    = 1'b0;
    accept  = outValid && tready;
    if (!outValid) begin
      strobes.loadOutWord = wordValid;
    end else if (accept) begin
      if (pendValid) begin
        strobes.loadOutPend = 1'b1;
        strobes.loadPend    = wordValid;
      end else begin
        strobes.loadOutWord = wordValid;
      end
    end else if (wordValid) begin
      if (!pendValid) strobes.loadPend = 1'b1;
      else            drop = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      pendValid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      outValid <= strobes.loadOutWord || strobes.loadOutPend || (outValid && !accept);
      if (strobes.loadPend)         pendValid <= 1'b1;
      else if (strobes.loadOutPend) pendValid <= 1'b0;
      overflow <= overflow || drop;
    end
  end

  // R8
  pend_behind_out_chk: assert property (@(posedge clk) disable iff (rst)
    pendValid |-> outValid);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R9
  drop_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (wordValid && outValid && !tready && pendValid) |=> overflow);

endmodule

// File: rtl/ddr_sample_stream.sv
module ddr_sample_stream
  import ddr_cap_pkg::*;
#(
  parameter int LANES = 6,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] laneData,
  input  logic             laneValid,
  input  logic             swapPair,
  input  logic             twosComp,
  output logic             tvalid,
  input  logic             tready,
  output logic [OUT_W-1:0] tdata,
  output logic             overflow
);

  localparam int SAMPLE_W = 2 * LANES;

  strobe_t strobes;
  logic    wordValid;

  ddr_cap_datapath #(.LANES(LANES), .OUT_W(OUT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .laneData  (laneData),
    .laneValid (laneValid),
    .swapPair  (swapPair),
    .twosComp  (twosComp),
    .strobes   (strobes),
    .wordValid (wordValid),
    .outData   (tdata)
  );

  ddr_cap_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wordValid (wordValid),
    .tready    (tready),
    .strobes   (strobes),
    .outValid  (tvalid),
    .overflow  (overflow)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tvalid && !tready) |=> (tvalid && $stable(tdata)));

  // R5
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (tvalid && twosComp) |-> (tdata[OUT_W-1:SAMPLE_W-1] == '0 || tdata[OUT_W-1:SAMPLE_W-1] == '1));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!tvalid && !overflow));

endmodule

// File: tb/ddr_sample_stream_test.sv
`timescale 1ns/1ps
module ddr_sample_stream_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  laneData = '0;
  logic        laneValid = 1'b0;
  logic        swapPair = 1'b0;
  logic        twosComp = 1'b0;
  logic        tvalid;
  logic        tready = 1'b1;
  logic [15:0] tdata;
  logic        overflow;

  int testCount = 0;
  int failCount = 0;
  int beatCount = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  ddr_sample_stream uut (
    .clk(clk), .rst(rst), .laneData(laneData), .laneValid(laneValid),
    .swapPair(swapPair), .twosComp(twosComp), .tvalid(tvalid),
    .tready(tready), .tdata(tdata), .overflow(overflow)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expectWord(input logic [11:0] code, input logic tc);
    logic top;
    top = code[11] ^ tc;
    return tc ? {{4{top}}, top, code[10:0]} : {4'b0000, code};
  endfunction

  // Drives one sample: rising half before the rising edge, falling half after it.
  task automatic sendSample(input logic [11:0] code, input logic v);
    logic [5:0] riseBits, fallBits;
    for (int k = 0; k < 6; k++) begin
      riseBits[k] = swapPair ? code[2*k+1] : code[2*k];
      fallBits[k] = swapPair ? code[2*k]   : code[2*k+1];
    end
    @(negedge clk); #1;
    laneData  = riseBits;
    laneValid = v;
    @(posedge clk); #1;
    laneData  = fallBits;
    laneValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Stream monitor: accepted beat is stable from the falling edge to the next rising edge
  always @(negedge clk) begin
    if (!rst && tvalid && tready) begin
      beatCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected beat", tdata, 0);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(tdata == e, t, tdata, e);
      end
    end
  end

  task automatic finishRun;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int b0;
    idle(3);
    #0 rst = 1'b0;
    idle(1);
    // R10: reset state
    check(tvalid == 1'b0, "R10 tvalid after reset", tvalid, 0);
    check(overflow == 1'b0, "R10 overflow after reset", overflow, 0);

    // R3: latency from rising-half capture to tvalid
    expQ.push_back(expectWord(12'h5A3, 1'b0)); tagQ.push_back("R3 latency data");
    sendSample(12'h5A3, 1'b1);       // rising half captured at edge P
    idle(1);                         // after P+1
    check(tvalid == 1'b0, "R3 not valid after P+1", tvalid, 0);
    idle(1);                         // after P+2
    check(tvalid == 1'b1, "R3 valid after P+2", tvalid, 1);
    idle(4);

    // R6: samples with laneValid low are ignored
    b0 = beatCount;
    for (int i = 0; i < 8; i++) sendSample(12'hFFF - i[11:0], 1'b0);
    idle(5);
    check(beatCount == b0, "R6 no beats from idle lanes", beatCount - b0, 0);
    check(tvalid == 1'b0, "R6 tvalid stays low", tvalid, 0);

    // R1 R2 R4 R5: every code in every pair order and format
    for (int m = 0; m < 4; m++) begin
      swapPair = m[0];
      twosComp = m[1];
      idle(3);
      for (int c = 0; c < 4096; c++) begin
        expQ.push_back(expectWord(c[11:0], twosComp));
        tagQ.push_back(m[1] ? (m[0] ? "R2 R5 sweep" : "R1 R5 sweep")
                            : (m[0] ? "R2 R4 sweep" : "R1 R4 sweep"));
        sendSample(c[11:0], 1'b1);
      end
      idle(6);
      check(expQ.size() == 0, "R1 sweep drained", expQ.size(), 0);
    end
    swapPair = 1'b0;
    twosComp = 1'b0;
    idle(4);
    check(overflow == 1'b0, "R9 no drop at full rate", overflow, 0);

    // R7 R8 R9: stall with four arrivals
    tready = 1'b0;
    sendSample(12'h111, 1'b1);
    sendSample(12'h222, 1'b1);
    sendSample(12'h333, 1'b1);
    sendSample(12'h444, 1'b1);
    idle(4);
    check(tvalid == 1'b1, "R7 held valid", tvalid, 1);
    check(tdata == 16'h0111, "R7 held data", tdata, 16'h0111);
    check(overflow == 1'b1, "R9 overflow set", overflow, 1);
    idle(3);
    check(tdata == 16'h0111, "R7 data still held", tdata, 16'h0111);
    expQ.push_back(16'h0111); tagQ.push_back("R8 first kept");
    expQ.push_back(16'h0222); tagQ.push_back("R8 second kept");
    tready = 1'b1;
    idle(5);
    check(expQ.size() == 0, "R8 both kept delivered", expQ.size(), 0);
    check(tvalid == 1'b0, "R9 dropped samples absent", tvalid, 0);
    check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
    expQ.push_back(16'h0ABC); tagQ.push_back("R9 flow after drop");
    sendSample(12'hABC, 1'b1);
    idle(5);
    check(overflow == 1'b1, "R9 overflow still set", overflow, 1);

    // R10: reset with both slots full discards them
    tready = 1'b0;
    sendSample(12'h777, 1'b1);
    sendSample(12'h888, 1'b1);
    idle(4);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    tready = 1'b1;
    b0 = beatCount;
    idle(6);
    check(tvalid == 1'b0, "R10 tvalid cleared", tvalid, 0);
    check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
    check(beatCount == b0, "R10 pending discarded", beatCount - b0, 0);

    finishRun();
  end

endmodule